// File: doc/BRIEF.md
# Add-Class Integer ALU with Carry and Overflow Flags

This unit carries out every addition-type operation of a 64-bit integer pipeline: register and immediate adds, reverse subtraction (B minus A), the extended forms that chain a carry flag in, negation, and one add that chains through the overflow flag. Every operation reduces to a single sum A' + B' + cin. A' is A or its complement. B' is the B register, the sign-extended 16-bit immediate, all ones or zero. The carry-in is 0, 1, the incoming CA flag or the incoming OV flag.

The sum produces carry and signed overflow at both the 64-bit and the 32-bit boundary, a sticky summary-overflow bit and an optional 4-bit condition field. The caller provides the current flag values. A flag that the operation does not produce comes back unchanged, so the caller can write every flag back without extra masking.

A one-cycle request (`valid_i`) is captured at the next clock edge. The result is then presented with `valid_o` high for one cycle. A two-state output sequencer runs this handshake. **IDLE** moves to **EMIT** on a request. **EMIT** stays in EMIT when a back-to-back request arrives and returns to IDLE otherwise.

Top module: `addflag_alu`

## Requirements
- R1: The operation code `op_i` selects the operand mapping (A', B', cin): 0 = (A, B, 0); 2 = (~A, B, 1); 4 = (A, B, CA); 5 = (~A, B, CA); 6 = (A, all ones, CA); 7 = (A, 0, CA); 8 = (~A, all ones, CA); 9 = (~A, 0, CA); 10 = (~A, 0, 1). Codes 12 to 15 behave as code 0. The result is the low 64 bits of the sum.
- R2: Code 1 = (A, imm, 0) and code 3 = (~A, imm, 1). Here imm is `imm_i` sign-extended from bit 15, so 0x8000 is taken as -32768.
- R3: CA is the carry out of the full 64-bit sum. CA32 is the carry out of bits 31..0 of A' + B' + cin. Both are written only when `ca_en_i` is 1 and the code is not 11.
- R4: OV is (carry out of bit 63) XOR (carry out of the low 63 bits). OV32 is (carry out of the low 32 bits) XOR (carry out of the low 31 bits). Both are written only when `ov_en_i` is 1.
- R5: Code 11 maps to (A, B, OV). It always writes the 64-bit carry-out into OV and the 32-bit carry-out into OV32, and it leaves CA and CA32 unchanged.
- R6: When `ov_en_i` is 1, SO becomes the incoming SO OR the new OV, so a set SO never clears. When `ov_en_i` is 0, SO passes through unchanged.
- R7: When `rec_en_i` is 1, `cr_o` holds lt at bit 3, gt at bit 2, eq at bit 1 and the new SO at bit 0, and `cr_wr_o` is 1. lt is result bit 63. eq means the result is zero. gt means neither lt nor eq. When `rec_en_i` is 0, `cr_o` is 0000 and `cr_wr_o` is 0.
- R8: Every flag that an operation does not write is returned equal to its incoming value.
- R9: A request with `valid_i` high gives `valid_o` high for exactly the following cycle, together with the result and flags of that request. Without a request, `valid_o` is low. After reset all outputs are zero.
- R10: Negating zero (code 10) with overflow and record enabled and SO clear gives result 0, OV 0, OV32 0, SO 0 and `cr_o` = 0010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request strobe |
| op_i | input | 4 | Operation code |
| a_i | input | 64 | Register operand A |
| b_i | input | 64 | Register operand B |
| imm_i | input | 16 | Signed immediate |
| ca_i | input | 1 | Current CA |
| ca32_i | input | 1 | Current CA32 |
| ov_i | input | 1 | Current OV |
| ov32_i | input | 1 | Current OV32 |
| so_i | input | 1 | Current SO |
| ca_en_i | input | 1 | Carry-output enable |
| ov_en_i | input | 1 | Overflow-output enable |
| rec_en_i | input | 1 | Record (condition field) enable |
| valid_o | output | 1 | Result strobe |
| res_o | output | 64 | Sum |
| ca_o | output | 1 | New CA |
| ca32_o | output | 1 | New CA32 |
| ov_o | output | 1 | New OV |
| ov32_o | output | 1 | New OV32 |
| so_o | output | 1 | New SO |
| cr_o | output | 4 | Condition field |
| cr_wr_o | output | 1 | Condition field is valid |

## Verification
The assertions assume that each input is stable while it is sampled at the capturing edge. They also assume that the enable and operation inputs seen with `valid_i` belong to that request alone, because the pass-through checks compare each output with the inputs of the previous cycle. The bench meets these assumptions by changing inputs only on the falling edge. It raises `valid_i` for a single cycle per request and checks each result before it sends the next request. It sweeps all sixteen codes over the corner operands with both values of every incoming flag, then adds seeded random operands and enables.

// File: rtl/addop_pkg.sv
package addop_pkg;

    typedef enum logic [3:0] {
        OP_ADD_RR      = 4'd0,
        OP_ADD_IMM     = 4'd1,
        OP_RSUB_RR     = 4'd2,
        OP_RSUB_IMM    = 4'd3,
        OP_ADD_EXT     = 4'd4,
        OP_RSUB_EXT    = 4'd5,
        OP_ADD_M1_EXT  = 4'd6,
        OP_ADD_Z_EXT   = 4'd7,
        OP_RSUB_M1_EXT = 4'd8,
        OP_RSUB_Z_EXT  = 4'd9,
        OP_NEGATE      = 4'd10,
        OP_ADD_OVCARRY = 4'd11,
        OP_RSV12       = 4'd12,
        OP_RSV13       = 4'd13,
        OP_RSV14       = 4'd14,
        OP_RSV15       = 4'd15
    } add_op_e;

    typedef enum logic [1:0] {
        BSRC_REG  = 2'd0,
        BSRC_IMM  = 2'd1,
        BSRC_ONES = 2'd2,
        BSRC_ZERO = 2'd3
    } bsrc_e;

    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_CA   = 2'd2,
        CIN_OV   = 2'd3
    } cin_e;

    typedef struct packed {
        logic  inv_a;
        bsrc_e bsrc;
        cin_e  cin;
        logic  ov_carry;
    } add_ctl_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } out_state_e;

endpackage

// File: rtl/addop_decode.sv
module addop_decode
    import addop_pkg::*;
(
    input  logic [3:0] op_i,
    output add_ctl_t   ctl_o
);
    add_op_e op;
    assign op = add_op_e'(op_i);

    always_comb begin
        ctl_o = '{inv_a: 1'b0, bsrc: BSRC_REG, cin: CIN_ZERO, ov_carry: 1'b0};
        unique case (op)
            OP_ADD_IMM:     ctl_o = '{inv_a: 1'b0, bsrc: BSRC_IMM,  cin: CIN_ZERO, ov_carry: 1'b0};
            OP_RSUB_RR:     ctl_o = '{inv_a: 1'b1, bsrc: BSRC_REG,  cin: CIN_ONE,  ov_carry: 1'b0};
            OP_RSUB_IMM:    ctl_o = '{inv_a: 1'b1, bsrc: BSRC_IMM,  cin: CIN_ONE,  ov_carry: 1'b0};
            OP_ADD_EXT:     ctl_o = '{inv_a: 1'b0, bsrc: BSRC_REG,  cin: CIN_CA,   ov_carry: 1'b0};
            OP_RSUB_EXT:    ctl_o = '{inv_a: 1'b1, bsrc: BSRC_REG,  cin: CIN_CA,   ov_carry: 1'b0};
            OP_ADD_M1_EXT:  ctl_o = '{inv_a: 1'b0, bsrc: BSRC_ONES, cin: CIN_CA,   ov_carry: 1'b0};
            OP_ADD_Z_EXT:   ctl_o = '{inv_a: 1'b0, bsrc: BSRC_ZERO, cin: CIN_CA,   ov_carry: 1'b0};
            OP_RSUB_M1_EXT: ctl_o = '{inv_a: 1'b1, bsrc: BSRC_ONES, cin: CIN_CA,   ov_carry: 1'b0};
            OP_RSUB_Z_EXT:  ctl_o = '{inv_a: 1'b1, bsrc: BSRC_ZERO, cin: CIN_CA,   ov_carry: 1'b0};
            OP_NEGATE:      ctl_o = '{inv_a: 1'b1, bsrc: BSRC_ZERO, cin: CIN_ONE,  ov_carry: 1'b0};
            OP_ADD_OVCARRY: ctl_o = '{inv_a: 1'b0, bsrc: BSRC_REG,  cin: CIN_OV,   ov_carry: 1'b1};
            default:        ctl_o = '{inv_a: 1'b0, bsrc: BSRC_REG,  cin: CIN_ZERO, ov_carry: 1'b0};
        endcase
    end
endmodule

// File: rtl/addop_operands.sv
module addop_operands
    import addop_pkg::*;
#(
    parameter int W     = 64,
    parameter int IMM_W = 16
) (
    input  add_ctl_t           ctl_i,
    input  logic [W-1:0]       a_i,
    input  logic [W-1:0]       b_i,
    input  logic [IMM_W-1:0]   imm_i,
    input  logic               ca_i,
    input  logic               ov_i,
    output logic [W-1:0]       a_eff_o,
    output logic [W-1:0]       b_eff_o,
    output logic               cin_o
);
    localparam int EXT_W = W - IMM_W;

    logic [W-1:0] imm_sx;
    assign imm_sx  = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    assign a_eff_o = ctl_i.inv_a ? ~a_i : a_i;

    always_comb begin
        unique case (ctl_i.bsrc)
            BSRC_REG:  b_eff_o = b_i;
            BSRC_IMM:  b_eff_o = imm_sx;
            BSRC_ONES: b_eff_o = '1;
            default:   b_eff_o = '0;
        endcase
    end

    always_comb begin
        unique case (ctl_i.cin)
            CIN_ZERO: cin_o = 1'b0;
            CIN_ONE:  cin_o = 1'b1;
            CIN_CA:   cin_o = ca_i;
            default:  cin_o = ov_i;
        endcase
    end
endmodule

// File: rtl/addop_core.sv
module addop_core #(
    parameter int W  = 64,
    parameter int HW = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         c_full_o,
    output logic         c_top_o,
    output logic         c_half_o,
    output logic         c_half_lo_o
);
    logic [W:0] s;
    assign s           = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    assign sum_o       = s[W-1:0];
    assign c_full_o    = s[W];
    // carry into bit k recovered as sum ^ a ^ b at bit k
    assign c_top_o     = s[W-1]  ^ a_i[W-1]  ^ b_i[W-1];
    assign c_half_o    = s[HW]   ^ a_i[HW]   ^ b_i[HW];
    assign c_half_lo_o = s[HW-1] ^ a_i[HW-1] ^ b_i[HW-1];
endmodule

// File: rtl/addop_flags.sv
module addop_flags #(
    parameter int W = 64
) (
    input  logic [W-1:0] sum_i,
    input  logic         c_full_i,
    input  logic         c_top_i,
    input  logic         c_half_i,
    input  logic         c_half_lo_i,
    input  logic         ov_carry_i,
    input  logic         ca_en_i,
    input  logic         ov_en_i,
    input  logic         rec_en_i,
    input  logic         ca_i,
    input  logic         ca32_i,
    input  logic         ov_i,
    input  logic         ov32_i,
    input  logic         so_i,
    output logic         ca_o,
    output logic         ca32_o,
    output logic         ov_o,
    output logic         ov32_o,
    output logic         so_o,
    output logic [3:0]   cr_o
);
    logic lt, eq, gt;

    always_comb begin
        if (ca_en_i && !ov_carry_i) begin
            ca_o   = c_full_i;
            ca32_o = c_half_i;
        end else begin
            ca_o   = ca_i;
            ca32_o = ca32_i;
        end

        if (ov_carry_i) begin
            ov_o   = c_full_i;
            ov32_o = c_half_i;
        end else if (ov_en_i) begin
            ov_o   = c_full_i ^ c_top_i;
            ov32_o = c_half_i ^ c_half_lo_i;
        end else begin
            ov_o   = ov_i;
            ov32_o = ov32_i;
        end

        so_o = ov_en_i ? (so_i | ov_o) : so_i;
    end

    assign lt   = sum_i[W-1];
    assign eq   = (sum_i == '0);
    assign gt   = !lt && !eq;
    assign cr_o = rec_en_i ? {lt, gt, eq, so_o} : 4'b0000;
endmodule

// File: rtl/addflag_alu.sv
module addflag_alu
    import addop_pkg::*;
#(
    parameter int W     = 64,
    parameter int HW    = 32,
    parameter int IMM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [3:0]        op_i,
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      b_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              ca_i,
    input  logic              ca32_i,
    input  logic              ov_i,
    input  logic              ov32_i,
    input  logic              so_i,
    input  logic              ca_en_i,
    input  logic              ov_en_i,
    input  logic              rec_en_i,
    output logic              valid_o,
    output logic [W-1:0]      res_o,
    output logic              ca_o,
    output logic              ca32_o,
    output logic              ov_o,
    output logic              ov32_o,
    output logic              so_o,
    output logic [3:0]        cr_o,
    output logic              cr_wr_o
);
    add_ctl_t     ctl;
    logic [W-1:0] a_eff, b_eff, sum;
    logic         cin, c_full, c_top, c_half, c_half_lo;
    logic         n_ca, n_ca32, n_ov, n_ov32, n_so;
    logic [3:0]   n_cr;
    out_state_e   state, state_nx;

    addop_decode u_dec (.op_i(op_i), .ctl_o(ctl));

    addop_operands #(.W(W), .IMM_W(IMM_W)) u_opnd (
        .ctl_i(ctl), .a_i(a_i), .b_i(b_i), .imm_i(imm_i),
        .ca_i(ca_i), .ov_i(ov_i),
        .a_eff_o(a_eff), .b_eff_o(b_eff), .cin_o(cin)
    );

    addop_core #(.W(W), .HW(HW)) u_core (
        .a_i(a_eff), .b_i(b_eff), .cin_i(cin), .sum_o(sum),
        .c_full_o(c_full), .c_top_o(c_top),
        .c_half_o(c_half), .c_half_lo_o(c_half_lo)
    );

    addop_flags #(.W(W)) u_flg (
        .sum_i(sum), .c_full_i(c_full), .c_top_i(c_top),
        .c_half_i(c_half), .c_half_lo_i(c_half_lo),
        .ov_carry_i(ctl.ov_carry), .ca_en_i(ca_en_i), .ov_en_i(ov_en_i),
        .rec_en_i(rec_en_i), .ca_i(ca_i), .ca32_i(ca32_i), .ov_i(ov_i),
        .ov32_i(ov32_i), .so_i(so_i),
        .ca_o(n_ca), .ca32_o(n_ca32), .ov_o(n_ov), .ov32_o(n_ov32),
        .so_o(n_so), .cr_o(n_cr)
    );

    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = valid_i ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_nx = valid_i ? ST_EMIT : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_o   <= '0;
            ca_o    <= 1'b0;
            ca32_o  <= 1'b0;
            ov_o    <= 1'b0;
            ov32_o  <= 1'b0;
            so_o    <= 1'b0;
            cr_o    <= 4'b0000;
            cr_wr_o <= 1'b0;
        end else if (valid_i) begin
            res_o   <= sum;
            ca_o    <= n_ca;
            ca32_o  <= n_ca32;
            ov_o    <= n_ov;
            ov32_o  <= n_ov32;
            so_o    <= n_so;
            cr_o    <= n_cr;
            cr_wr_o <= rec_en_i;
        end
    end

    assign valid_o = (state == ST_EMIT);
endmodule

// File: rtl/addflag_alu_chk.sv
module addflag_alu_chk #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic         valid_i,
    input logic [3:0]   op_i,
    input logic         ca_i,
    input logic         ca32_i,
    input logic         ov_i,
    input logic         ov32_i,
    input logic         so_i,
    input logic         ca_en_i,
    input logic         ov_en_i,
    input logic         rec_en_i,
    input logic         valid_o,
    input logic [W-1:0] res_o,
    input logic         ca_o,
    input logic         ca32_o,
    input logic         ov_o,
    input logic         ov32_o,
    input logic         so_o,
    input logic [3:0]   cr_o,
    input logic         cr_wr_o
);
    // R9: a request yields a result strobe on the next cycle
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);
    // R9: no strobe without a request
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !valid_o);
    // R6: SO never clears
    a_r6_so_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && so_i) |=> so_o);
    // R6: SO passes through when overflow output is off
    a_r6_so_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !ov_en_i) |=> (so_o == $past(so_i)));
    // R3, R5, R8: carry flags kept when not written
    a_r8_ca_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (!ca_en_i || op_i == 4'd11)) |=>
            (ca_o == $past(ca_i) && ca32_o == $past(ca32_i)));
    // R4, R8: overflow flags kept when not written
    a_r8_ov_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !ov_en_i && op_i != 4'd11) |=>
            (ov_o == $past(ov_i) && ov32_o == $past(ov32_i)));
    // R7: exactly one of lt, gt, eq on a record result
    a_r7_one_relation: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && cr_wr_o) |-> ($countones(cr_o[3:1]) == 1));
    // R7: lt tracks the result sign and SO copy tracks SO
    a_r7_lt_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && cr_wr_o) |-> (cr_o[3] == res_o[W-1] && cr_o[0] == so_o));
    // R7: field cleared when record is off
    a_r7_no_record: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !rec_en_i) |=> (cr_o == 4'b0000 && !cr_wr_o));
endmodule

bind addflag_alu addflag_alu_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
    .ca_i(ca_i), .ca32_i(ca32_i), .ov_i(ov_i), .ov32_i(ov32_i), .so_i(so_i),
    .ca_en_i(ca_en_i), .ov_en_i(ov_en_i), .rec_en_i(rec_en_i),
    .valid_o(valid_o), .res_o(res_o), .ca_o(ca_o), .ca32_o(ca32_o),
    .ov_o(ov_o), .ov32_o(ov32_o), .so_o(so_o), .cr_o(cr_o), .cr_wr_o(cr_wr_o)
);

// File: tb/sim_addflag_alu.sv
`timescale 1ns/1ps
module sim_addflag_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [63:0] a_i = '0, b_i = '0;
    logic [15:0] imm_i = '0;
    logic ca_i = 0, ca32_i = 0, ov_i = 0, ov32_i = 0, so_i = 0;
    logic ca_en_i = 0, ov_en_i = 0, rec_en_i = 0;
    logic        valid_o, ca_o, ca32_o, ov_o, ov32_o, so_o, cr_wr_o;
    logic [63:0] res_o;
    logic [3:0]  cr_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    addflag_alu u0 (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .imm_i(imm_i),
        .ca_i(ca_i), .ca32_i(ca32_i), .ov_i(ov_i), .ov32_i(ov32_i), .so_i(so_i),
        .ca_en_i(ca_en_i), .ov_en_i(ov_en_i), .rec_en_i(rec_en_i),
        .valid_o(valid_o), .res_o(res_o), .ca_o(ca_o), .ca32_o(ca32_o),
        .ov_o(ov_o), .ov32_o(ov32_o), .so_o(so_o), .cr_o(cr_o), .cr_wr_o(cr_wr_o)
    );

    function automatic logic [63:0] corner(input int k);
        case (k)
            0: return 64'h0;
            1: return 64'h1;
            2: return 64'hFFFF_FFFF_FFFF_FFFF;
            3: return 64'h7FFF_FFFF_FFFF_FFFF;
            default: return 64'h8000_0000_0000_0000;
        endcase
    endfunction

    function automatic logic [15:0] imm_corner(input int k);
        case (k)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'hFFFF;
            3: return 16'h7FFF;
            default: return 16'h8000;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s op=%0d actual=%h expected=%h", tag, op_i, act, exp);
        end
    endtask

    // reference built from the requirement text with wide arithmetic
    task automatic model(output logic [63:0] r, output logic eca, eca32, eov, eov32, eso,
                         output logic [3:0] ecr);
        logic [63:0] ap, bp, sx;
        logic        ci, ovc;
        logic [65:0] f64, f63, f32, f31;
        logic        c64, c63, c32, c31;
        sx  = {{48{imm_i[15]}}, imm_i};
        ovc = 1'b0;
        case (op_i)
            4'd1:  begin ap = a_i;  bp = sx;    ci = 1'b0; end
            4'd2:  begin ap = ~a_i; bp = b_i;   ci = 1'b1; end
            4'd3:  begin ap = ~a_i; bp = sx;    ci = 1'b1; end
            4'd4:  begin ap = a_i;  bp = b_i;   ci = ca_i; end
            4'd5:  begin ap = ~a_i; bp = b_i;   ci = ca_i; end
            4'd6:  begin ap = a_i;  bp = '1;    ci = ca_i; end
            4'd7:  begin ap = a_i;  bp = '0;    ci = ca_i; end
            4'd8:  begin ap = ~a_i; bp = '1;    ci = ca_i; end
            4'd9:  begin ap = ~a_i; bp = '0;    ci = ca_i; end
            4'd10: begin ap = ~a_i; bp = '0;    ci = 1'b1; end
            4'd11: begin ap = a_i;  bp = b_i;   ci = ov_i; ovc = 1'b1; end
            default: begin ap = a_i; bp = b_i;  ci = 1'b0; end
        endcase
        f64 = {2'b0, ap} + {2'b0, bp} + 66'(ci);
        f63 = 66'(ap[62:0]) + 66'(bp[62:0]) + 66'(ci);
        f32 = 66'(ap[31:0]) + 66'(bp[31:0]) + 66'(ci);
        f31 = 66'(ap[30:0]) + 66'(bp[30:0]) + 66'(ci);
        c64 = f64[64]; c63 = f63[63]; c32 = f32[32]; c31 = f31[31];
        r = f64[63:0];
        if (ca_en_i && !ovc) begin eca = c64; eca32 = c32; end
        else begin eca = ca_i; eca32 = ca32_i; end
        if (ovc) begin eov = c64; eov32 = c32; end
        else if (ov_en_i) begin eov = c64 ^ c63; eov32 = c32 ^ c31; end
        else begin eov = ov_i; eov32 = ov32_i; end
        eso = ov_en_i ? (so_i | eov) : so_i;
        if (rec_en_i)
            ecr = {r[63], !r[63] && (r != 0), (r == 0), eso};
        else
            ecr = 4'b0000;
    endtask

    task automatic run_one;
        logic [63:0] r; logic eca, eca32, eov, eov32, eso; logic [3:0] ecr;
        string rt;
        model(r, eca, eca32, eov, eov32, eso, ecr);
        rt = (op_i == 4'd1 || op_i == 4'd3) ? "R2 result" :
             (op_i == 4'd11) ? "R5 result" : "R1 result";
        valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        check(valid_o === 1'b1, "R9 valid", 64'(valid_o), 64'd1);
        check(res_o === r, rt, res_o, r);
        check({ca_o, ca32_o} === {eca, eca32}, "R3/R8 carry flags", 64'({ca_o, ca32_o}), 64'({eca, eca32}));
        check({ov_o, ov32_o} === {eov, eov32},
              (op_i == 4'd11) ? "R5 ov flags" : "R4/R8 ov flags",
              64'({ov_o, ov32_o}), 64'({eov, eov32}));
        check(so_o === eso, "R6 so", 64'(so_o), 64'(eso));
        check(cr_o === ecr && cr_wr_o === rec_en_i, "R7 cond field",
              64'({cr_wr_o, cr_o}), 64'({rec_en_i, ecr}));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(negedge clk);
        // R9: reset state
        check(valid_o === 1'b0 && res_o === 64'd0 && cr_o === 4'd0 && so_o === 1'b0,
              "R9 reset", {59'd0, valid_o, cr_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: negate zero with overflow and record
        op_i = 4'd10; a_i = 0; b_i = 0; ov_en_i = 1; rec_en_i = 1; ca_en_i = 0;
        ca_i = 0; ca32_i = 0; ov_i = 0; ov32_i = 0; so_i = 0;
        valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        check(res_o === 64'd0 && ov_o === 0 && ov32_o === 0 && so_o === 0 && cr_o === 4'b0010,
              "R10 negate zero", {res_o[55:0], ov_o, ov32_o, so_o, 1'b0, cr_o}, 64'h2);
        @(negedge clk);
        // R9: strobe lasts one cycle
        check(valid_o === 1'b0, "R9 single strobe", 64'(valid_o), 64'd0);

        // R10: SO already set stays set, copied into the field
        so_i = 1; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        check(so_o === 1 && cr_o === 4'b0011, "R10 negate zero so set", 64'(cr_o), 64'h3);

        // corner sweep over all codes, operands and incoming flags
        for (int op = 0; op < 16; op++)
            for (int ka = 0; ka < 5; ka++)
                for (int kb = 0; kb < 5; kb++)
                    for (int fl = 0; fl < 4; fl++) begin
                        op_i = 4'(op); a_i = corner(ka); b_i = corner(kb);
                        imm_i = imm_corner(kb);
                        ca_i = fl[0]; ov_i = fl[1];
                        ca32_i = $urandom_range(0, 1); ov32_i = $urandom_range(0, 1);
                        so_i = $urandom_range(0, 1);
                        ca_en_i = $urandom_range(0, 1); ov_en_i = $urandom_range(0, 1);
                        rec_en_i = $urandom_range(0, 1);
                        run_one();
                    end

        // random operands, back-to-back and idle gaps mixed
        for (int i = 0; i < 3000; i++) begin
            op_i = 4'($urandom_range(0, 15));
            a_i = {$urandom, $urandom}; b_i = {$urandom, $urandom};
            if (i % 4 == 0) a_i[62:0] = '1;
            imm_i = 16'($urandom);
            {ca_i, ca32_i, ov_i, ov32_i, so_i} = 5'($urandom);
            {ca_en_i, ov_en_i, rec_en_i} = 3'($urandom);
            run_one();
            if (i % 7 == 0) begin
                @(negedge clk);
                check(valid_o === 1'b0, "R9 idle", 64'(valid_o), 64'd0);
            end
        end

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule